// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. Software reaches it through four 32-bit registers: configuration, address, data and operation. A write to the operation register starts one frame. The block divides the core clock down to MDC. It drives the bidirectional MDIO line through separate output, output-enable and input pins, which the pad ring combines.

The block sends two frame styles, and a configuration bit picks one of them. Direct frames address a PHY register in one transaction. Indirect frames use an address cycle first and then a data cycle. The data cycle is a write or a read. For a read, the master lets go of the line during turnaround and the data phase. It samples the line on each MDC rising edge and puts the 16-bit result in the data register when the frame ends. A busy flag is set while a frame is on the wire. While busy is set, writes to the operation register have no effect.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, all four registers read zero (after reset only), busy is clear, MDC is low and mdio_oe is low.
- R2: The register index wr_sel/rd_sel selects a register: 0 is configuration, 1 is address, 2 is data, 3 is operation. Configuration reads back four bits and the divider. Bit 0 enables MDI, bit 1 inverts MDI, bit 2 enables the preamble and bit 3 selects indirect frames. The divider sits in bits [5 +: DIV_W]. The other configuration bits read zero. Address reads back bits 9:0, and data reads back all 32 bits.
- R3: Each MDC half-period lasts (divider + 1) core clocks. The divider is taken from the configuration register when the frame starts.
- R4: A frame sends its bits MSB first, one per MDC period, in this order: start code (2 bits), opcode (2 bits, the written op[1:0]), PHY address (address bits 9:5), register or device number (address bits 4:0), turnaround (2 bits) and 16 data bits. A write or address frame drives turnaround as 10 and puts data register bits 15:0 in the data field. MDIO changes only in the cycle after an MDC falling edge or the cycle after a start.
- R5: When configuration bit 2 is set, 32 driven ones come before the start code. When it is clear, the frame begins at the start code.
- R6: Opcodes 2 and 3 are reads. During the last 18 bit periods (turnaround and data), mdio_oe is low. MDIO is sampled at each MDC rise of the data phase, MSB first. When busy clears, the result replaces data register bits 15:0 and bits 31:16 keep their value.
- R7: The start code is 01 when configuration bit 3 is clear and 00 when it is set. Opcode 0 sends an address frame whose data field carries data register bits 15:0. Opcode 3 reads the result back.
- R8: Busy (operation register bit 31) reads 1 from the cycle after the accepted operation write. It stays 1 for exactly nbits*2*(divider+1) cycles, where nbits is 64 with the preamble and 32 without it.
- R9: A write to the operation register while busy is set is ignored: the opcode read back, the frame on the wire and the busy length are unchanged, and no frame follows.
- R10: When configuration bit 0 is clear, the captured read data is all zeros. When bit 0 is set and bit 1 is set, every sampled bit is inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register index for reads |
| rd_data | output | 32 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_out | output | 1 | Value driven on MDIO |
| mdio_in | input | 1 | Value seen on the MDIO pad |

## Verification
The bench builds the block with the default DIV_W of 8. Configuration readback therefore covers a full-width divider field, and that field lands in bits 12:5. In the frame tests the bench programs divider values from 0 to 3. These short settings keep every complete 64-bit preamble frame to a few hundred cycles, so direct and indirect frames can all run in sequence. The same settings let the bench compare exact busy lengths and MDC half-periods against the formula. A responder in the bench records every bit at the MDC rise and drives read data on the MDC fall.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS  = 32;
  localparam int BODY_BITS = 32;
  localparam int TA_POS    = 14;  // body position of first turnaround bit
  localparam int DATA_POS  = 16;  // body position of first data bit
  localparam int FIELD_W   = 5;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RDIDX = 2'd3
  } mdio_op_e;

  localparam logic [1:0] ST_DIRECT   = 2'b01;
  localparam logic [1:0] ST_INDIRECT = 2'b00;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[1];
  endfunction

  // Frame body after the optional preamble, MSB first on the wire.
  function automatic logic [BODY_BITS-1:0] mdio_body(
      input logic indirect, input logic [1:0] op,
      input logic [FIELD_W-1:0] phy, input logic [FIELD_W-1:0] regn,
      input logic [15:0] payload);
    logic [1:0] st;
    logic [1:0] ta;
    st = indirect ? ST_INDIRECT : ST_DIRECT;
    ta = op_is_read(op) ? 2'b00 : 2'b10;
    return {st, op, phy, regn, ta, payload};
  endfunction

  // Core clocks a whole frame keeps the block busy.
  function automatic int unsigned frame_cycles(input logic pre, input int unsigned div);
    return (pre ? (PRE_BITS + BODY_BITS) : BODY_BITS) * 2 * (div + 1);
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = run && (cnt_q == div);
  assign rise_ev = wrap && !mdc;
  assign fall_ev = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= !mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 pre_en,
  input  logic                 rd_mode,
  input  logic [BODY_BITS-1:0] body,
  input  logic                 rise_ev,
  input  logic                 fall_ev,
  input  logic                 din,
  output logic                 active,
  output logic                 mdo,
  output logic                 mdoe,
  output logic                 done,
  output logic [15:0]          cap
);
  localparam int IDX_W = $clog2(PRE_BITS + BODY_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PRE_BITS + BODY_BITS - 1);
  localparam logic [IDX_W-1:0] BODY_IDX = IDX_W'(PRE_BITS);

  logic [IDX_W-1:0]     idx_q;
  logic [BODY_BITS-1:0] body_q;
  logic                 rd_q;
  logic                 in_body;
  logic [4:0]           pos;
  logic                 released;
  logic                 bit_val;
  logic                 last_bit;

  assign in_body  = idx_q[IDX_W-1];
  assign pos      = idx_q[4:0];
  assign released = rd_q && in_body && (pos >= 5'(TA_POS));
  assign bit_val  = in_body ? body_q[5'd31 - pos] : 1'b1;
  assign last_bit = (idx_q == LAST_IDX);

  assign mdoe = active && !released;
  assign mdo  = mdoe && bit_val;
  assign done = active && fall_ev && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx_q  <= '0;
      body_q <= '0;
      rd_q   <= 1'b0;
      cap    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx_q  <= pre_en ? '0 : BODY_IDX;
      body_q <= body;
      rd_q   <= rd_mode;
      cap    <= '0;
    end else if (active) begin
      if (rise_ev && rd_q && in_body && (pos >= 5'(DATA_POS)))
        cap <= {cap[14:0], din};
      if (fall_ev) begin
        if (last_bit) active <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_oe,
  output logic        mdio_out,
  input  logic        mdio_in
);
  localparam int DIV_LSB = 5;
  localparam int ADDR_W  = 2 * FIELD_W;
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OP   = 2'd3;

  logic [3:0]        cfg_flags_q;
  logic [DIV_W-1:0]  cfg_div_q;
  logic [DIV_W-1:0]  run_div_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic [1:0]        op_q;

  // Named internal events for the checker.
  logic busy, go, op_blocked, rise_ev, fall_ev, eng_done, din;
  logic [15:0] cap;
  logic [BODY_BITS-1:0] body;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[31:DIV_LSB+DIV_W], wr_data[4]};

  assign go         = wr_en && (wr_sel == SEL_OP) && !busy;
  assign op_blocked = wr_en && (wr_sel == SEL_OP) && busy;
  assign din        = cfg_flags_q[0] && (mdio_in ^ cfg_flags_q[1]);
  assign body       = mdio_body(cfg_flags_q[3], wr_data[1:0],
                                addr_q[ADDR_W-1:FIELD_W], addr_q[FIELD_W-1:0],
                                data_q[15:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_flags_q <= '0;
      cfg_div_q   <= '0;
      run_div_q   <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      op_q        <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_CFG) begin
        cfg_flags_q <= wr_data[3:0];
        cfg_div_q   <= wr_data[DIV_LSB +: DIV_W];
      end
      if (wr_en && wr_sel == SEL_ADDR) addr_q <= wr_data[ADDR_W-1:0];
      if (go) begin
        op_q      <= wr_data[1:0];
        run_div_q <= cfg_div_q;
      end
      if (eng_done && op_is_read(op_q))
        data_q[15:0] <= cap;
      else if (wr_en && wr_sel == SEL_DATA)
        data_q <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CFG: begin
        rd_data[3:0]             = cfg_flags_q;
        rd_data[DIV_LSB +: DIV_W] = cfg_div_q;
      end
      SEL_ADDR: rd_data[ADDR_W-1:0] = addr_q;
      SEL_DATA: rd_data = data_q;
      default:  rd_data = {busy, 29'b0, op_q};
    endcase
  end

  mdio_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(run_div_q),
    .mdc(mdc), .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  mdio_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .start(go),
    .pre_en(cfg_flags_q[2]), .rd_mode(op_is_read(wr_data[1:0])),
    .body(body), .rise_ev(rise_ev), .fall_ev(fall_ev), .din(din),
    .active(busy), .mdo(mdio_out), .mdoe(mdio_oe), .done(eng_done), .cap(cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       op_blocked,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_oe,
  input logic       mdio_out,
  input logic       fall_ev,
  input logic [1:0] op_q
);
  assert_op_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_blocked |=> $stable(op_q));

  assert_mdc_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_go_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  assert_change_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !fall_ev) |=> ($stable(mdio_out) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .op_blocked(op_blocked), .busy(busy),
  .mdc(mdc), .mdio_oe(mdio_oe), .mdio_out(mdio_out), .fall_ev(fall_ev), .op_q(op_q)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  typedef struct packed {
    logic        pre;
    logic        ind;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic [15:0] resp;
    logic [3:0]  div;
    logic        inv;
    logic        en;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 2'd1, 5'h03, 5'h11, 16'hBEEF, 16'h0000, 4'd1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd2, 5'h1F, 5'h02, 16'h0000, 16'h8143, 4'd0, 1'b0, 1'b1},
    '{1'b1, 1'b0, 2'd2, 5'h00, 5'h1E, 16'h1234, 16'h7E01, 4'd2, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd0, 5'h05, 5'h01, 16'h0C0A, 16'h0000, 4'd1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 2'd3, 5'h05, 5'h01, 16'h0000, 16'hF00D, 4'd1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 2'd1, 5'h12, 5'h07, 16'h5A5A, 16'h0000, 4'd0, 1'b0, 1'b1},
    '{1'b0, 1'b0, 2'd2, 5'h09, 5'h0C, 16'h0000, 16'h3C96, 4'd1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 2'd2, 5'h09, 5'h0C, 16'h0000, 16'hFFFF, 4'd0, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_oe, mdio_out;
  logic mdio_in = 1'b0;

  int checks = 0, errors = 0;
  int rec_n = 0, cur_nbits = 64;
  logic [15:0] resp_g = '0;
  logic rec_oe [80];
  logic rec_out [80];

  always #4 clk = !clk;

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_oe(mdio_oe),
    .mdio_out(mdio_out), .mdio_in(mdio_in)
  );

  // PHY responder: record every bit at MDC rise, present read data on MDC fall.
  always @(posedge mdc) begin
    if (rec_n < 80) begin
      rec_oe[rec_n]  = mdio_oe;
      rec_out[rec_n] = mdio_out;
    end
    rec_n = rec_n + 1;
  end

  always @(negedge mdc) begin
    if (rec_n >= cur_nbits - 16 && rec_n < cur_nbits)
      mdio_in = resp_g[cur_nbits - 1 - rec_n];
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [31:0] val);
    rd_sel = sel;
    #1;
    val = rd_data;
  endtask

  // Own restatement of the frame layout: preamble, start, op, phy, reg, TA, data.
  task automatic compare_frame(input logic pre, input logic ind, input logic [1:0] op,
                               input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] data);
    logic [31:0] exp;
    int nb, bad, off;
    bad = -1;
    off = pre ? 32 : 0;
    nb  = off + 32;
    exp = {(ind ? 2'b00 : 2'b01), op, phy, rg, 2'b10, data};
    for (int i = 0; i < nb; i++) begin
      if (bad < 0) begin
        if (i < off) begin
          if (!(rec_oe[i] && rec_out[i])) bad = i;
        end else if (op[1] && (i - off) >= 14) begin
          if (rec_oe[i]) bad = i;
        end else begin
          if (!rec_oe[i] || rec_out[i] != exp[31 - (i - off)]) bad = i;
        end
      end
    end
    check(rec_n == nb, "R4 R5 bit count", rec_n, nb);
    check(bad < 0, "R4 R5 R6 R7 first wrong bit index", bad, 32'hFFFFFFFF);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] val, exp_data;
    int count, exp_dur;
    cur_nbits = v.pre ? 64 : 32;
    resp_g = v.resp;
    reg_write(2'd0, {23'b0, 4'b0, v.div, 1'b0, v.ind, v.pre, v.inv, v.en});
    reg_write(2'd1, {22'b0, v.phy, v.rg});
    reg_write(2'd2, {16'hC3C3, v.data});
    rec_n = 0;
    reg_write(2'd3, {30'b0, v.op});
    rd_sel = 2'd3;
    #1;
    count = 0;
    while (rd_data[31] && count < 5000) begin
      count++;
      @(negedge clk); #1;
    end
    exp_dur = cur_nbits * 2 * (int'(v.div) + 1);
    check(count == exp_dur, "R3 R8 busy length", count, exp_dur);
    compare_frame(v.pre, v.ind, v.op, v.phy, v.rg, v.data);
    if (v.op[1]) exp_data = {16'hC3C3, (v.en ? (v.resp ^ {16{v.inv}}) : 16'h0000)};
    else         exp_data = {16'hC3C3, v.data};
    reg_read(2'd2, val);
    check(val == exp_data, "R6 R10 data register after frame", val, exp_data);
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] val;
    int count, hi, last_hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), val);
      check(val == 32'h0, "R1 register after reset", val, 32'h0);
    end
    check(mdc == 1'b0, "R1 mdc idle", mdc, 0);
    check(mdio_oe == 1'b0, "R1 mdio_oe idle", mdio_oe, 0);

    // R2 readback
    reg_write(2'd0, 32'hFFFFFFFF);
    reg_read(2'd0, val);
    check(val == 32'h00001FEF, "R2 config readback", val, 32'h00001FEF);
    reg_write(2'd1, 32'hFFFFFFFF);
    reg_read(2'd1, val);
    check(val == 32'h000003FF, "R2 address readback", val, 32'h000003FF);
    reg_write(2'd2, 32'h12345678);
    reg_read(2'd2, val);
    check(val == 32'h12345678, "R2 data readback", val, 32'h12345678);

    // Vector table: direct/indirect, write/read/address, preamble on/off
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9 ignored operation write mid-frame, R3 half-period measurement
    cur_nbits = 64;
    reg_write(2'd0, {19'b0, 8'd3, 1'b0, 4'b0100});
    reg_write(2'd1, {22'b0, 5'h0A, 5'h15});
    reg_write(2'd2, 32'h00000F0F);
    rec_n = 0;
    reg_write(2'd3, 32'd1);
    rd_sel = 2'd3;
    #1;
    count = 0; hi = 0; last_hi = 0;
    while (rd_data[31] && count < 5000) begin
      count++;
      if (mdc) hi++;
      else if (hi != 0) begin last_hi = hi; hi = 0; end
      if (count == 20) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'd2; end
      if (count == 21) wr_en = 1'b0;
      if (count == 30) check(rd_data[1:0] == 2'd1, "R9 opcode kept while busy", rd_data[1:0], 1);
      @(negedge clk); #1;
    end
    check(count == 512, "R9 busy length after ignored write", count, 512);
    check(last_hi == 4, "R3 mdc high half-period", last_hi, 4);
    compare_frame(1'b1, 1'b0, 2'd1, 5'h0A, 5'h15, 16'h0F0F);
    repeat (40) @(negedge clk);
    reg_read(2'd3, val);
    check(val[31] == 1'b0, "R9 no frame after ignored write", val, 32'h1);
    check(rec_n == 64, "R9 no extra bits", rec_n, 64);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", {mdc, mdio_oe}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule